// File: doc/BRIEF.md
# Multicycle Control Sequencer for an 8-bit Load/Store Core

This block is the control unit of a multicycle 8-bit core. The datapath keeps the 16-bit instruction word in its own register, and the sequencer reads that word. The sequencer moves through one fetch step and then one, two or three execute steps, depending on the instruction. In every step it drives the datapath's load enables, register-file write strobes, data-memory write strobe and multiplexer selects, and it supplies four register indices: two write ports and two read ports.

Four instructions are decoded: clear-register, store-indirect-with-displacement through the Y pointer, indirect call through the Z pointer, and load-from-program-memory through the Z pointer. Any other word is handled as a no-operation. It gets one idle execute step and then returns to fetch. Support for the call and for the program-memory load can each be removed by a parameter. A removed instruction then decodes as a no-operation.

Top module: `mc_sequencer`

## Requirements
- R1: While `rst` is 1, every load, strobe, select and index output is 0. The step register is forced to fetch, so the first cycle with `rst` at 0 is a fetch step. A reset that arrives in the middle of an instruction abandons it.
- R2: In a fetch step, `ir_ld`, `pc_ld`, `npc_ld` and `ret_ld` are 1 and every other output is 0. In particular `pm_addr_sel`=0 (program memory addressed by PC).
- R3: Execute step counts are: clear 1, store 2, call 2, program load 3, no-operation 1. After the last execute step the next step is fetch. `npc_ld` is 0 in every execute step.
- R4: Clear is recognised when bits [15:10] are 001001 and {bit9, bits[3:0]} equals {bit8, bits[7:4]}, with Rd in bits [8:4]. In its execute step `rf_we_a`=1, `wa_idx`=`ra_idx`=`rb_idx`=Rd, `alu_op`=6 (exclusive-or) and `flag_we`=8'h1E (Z, N, V and S at bits 1, 2, 3 and 4).
- R5: Store is recognised when bits [15:14]=10, bit12=0, bit9=1 and bit3=1. Its displacement is q={bit13, bits[11:10], bits[2:0]}. In the first execute step `ra_idx`=28, `rb_idx`=29, `agu_ld`=1 and `agu_disp`=q.
- R6: In the second store step `dm_we`=1, `dm_addr_sel`=0 (address register), `dm_wdata_sel`=0 (read port A) and `ra_idx`=Rr from bits [8:4].
- R7: The call is the word 16'h9509. In its first execute step `dm_we`=1, `dm_addr_sel`=1 (stack pointer), `dm_wdata_sel`=1 (return address), `sp_ld`=1 and `sp_dec`=1.
- R8: In the second call step `ra_idx`=30, `rb_idx`=31, `pc_hi_ld`=1 and `pc_lo_ld`=1.
- R9: Program load is recognised when bits [15:9]=1001000 and bits [3:0]=0100, with Rd in bits [8:4]. Step 1 has `ra_idx`=30, `rb_idx`=31, `agu_ld`=1 and `agu_disp`=0. Step 2 has `pm_addr_sel`=1, `mdr_ld`=1 and `pm_byte_hi`=`z_lsb`. Step 3 has `rf_we_a`=1, `wa_idx`=Rd and `rf_src`=1.
- R10: Any output not named for a step is 0. `rf_we_b` and `wb_idx` stay 0. Any other word, including an exclusive-or of two different registers, gives an all-zero execute step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_word | input | 16 | Instruction register contents |
| z_lsb | input | 1 | Bit 0 of the Z pointer |
| ir_ld | output | 1 | Load instruction register |
| pc_ld | output | 1 | Load PC with PC+1 |
| npc_ld | output | 1 | Load next-PC register |
| ret_ld | output | 1 | Load return-address register |
| pc_hi_ld | output | 1 | Load PC high byte from read port B |
| pc_lo_ld | output | 1 | Load PC low byte from read port A |
| sp_ld | output | 1 | Update stack pointer |
| sp_dec | output | 1 | Stack pointer update is a decrement |
| rf_we_a | output | 1 | Register write port A strobe |
| rf_we_b | output | 1 | Register write port B strobe |
| wa_idx | output | 5 | Write port A index |
| wb_idx | output | 5 | Write port B index |
| ra_idx | output | 5 | Read port A index |
| rb_idx | output | 5 | Read port B index |
| alu_op | output | 4 | ALU function code |
| flag_we | output | 8 | Per-bit status flag write mask |
| rf_src | output | 1 | Write data source: 0 ALU, 1 memory data register |
| agu_ld | output | 1 | Load the address register from the pointer sum |
| agu_disp | output | 6 | Displacement added to the pointer |
| dm_we | output | 1 | Data memory write strobe |
| dm_addr_sel | output | 1 | Data address: 0 address register, 1 stack pointer |
| dm_wdata_sel | output | 1 | Write data: 0 read port A, 1 return address |
| pm_addr_sel | output | 1 | Program address: 0 PC, 1 address register shifted right |
| pm_byte_hi | output | 1 | Select the high byte of the program word |
| mdr_ld | output | 1 | Load the memory data register |

## Verification
The bench uses the default parameters. Both optional instructions are enabled, and the pointer bases are 28 and 30, so every execute length from one to three is reached, including the three-step path. Store displacements of 0, 21 and 63 cover the extremes of the split displacement field. Register fields 0, 31 and middle values are used, and both values of the byte-select bit are driven. A reset asserted in the second step of a program load shows that the instruction is abandoned and that fetch restarts cleanly.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
package mcs_pkg;

   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_EX1   = 2'd1,
      ST_EX2   = 2'd2,
      ST_EX3   = 2'd3
   } step_e;

   typedef enum logic [2:0] {
      OP_NOP   = 3'd0,
      OP_CLR   = 3'd1,
      OP_STD   = 3'd2,
      OP_ICALL = 3'd3,
      OP_LPM   = 3'd4
   } op_e;

   localparam logic [3:0] ALU_IDLE = 4'd0;
   localparam logic [3:0] ALU_XOR  = 4'd6;

   localparam int FLAG_POS_Z = 1;
   localparam int FLAG_POS_N = 2;
   localparam int FLAG_POS_V = 3;
   localparam int FLAG_POS_S = 4;

endpackage

// File: rtl/mcs_decode.sv
`timescale 1ns/1ps
module mcs_decode
   import mcs_pkg::*;
#(
   parameter int IR_W     = 16,
   parameter int IDX_W    = 5,
   parameter int DISP_W   = 6,
   parameter bit LPM_EN   = 1'b1,
   parameter bit ICALL_EN = 1'b1
) (
   input  logic [IR_W-1:0]   ir_word,
   output op_e               op,
   output logic [IDX_W-1:0]  reg_fld,
   output logic [DISP_W-1:0] disp,
   output logic [1:0]        ex_len
);

   localparam logic [15:0] CALL_WORD = 16'h9509;

   if (IR_W != 16 || IDX_W != 5 || DISP_W != 6) begin : g_bad_geom
      $error("mcs_decode: field layout needs IR_W=16, IDX_W=5, DISP_W=6");
   end

   logic clr_hit, std_hit, icall_hit, lpm_hit;

   assign clr_hit = (ir_word[15:10] == 6'b001001) &&
                    (ir_word[9] == ir_word[8]) &&
                    (ir_word[3:0] == ir_word[7:4]);

   assign std_hit = (ir_word[15:14] == 2'b10) && !ir_word[12] &&
                    ir_word[9] && ir_word[3];

   if (ICALL_EN) begin : g_icall
      assign icall_hit = (ir_word == CALL_WORD);
   end else begin : g_no_icall
      assign icall_hit = 1'b0;
   end

   if (LPM_EN) begin : g_lpm
      assign lpm_hit = (ir_word[15:9] == 7'b1001000) && (ir_word[3:0] == 4'b0100);
   end else begin : g_no_lpm
      assign lpm_hit = 1'b0;
   end

   always_comb begin
      op     = OP_NOP;
      ex_len = 2'd1;
      if (clr_hit) begin
         op     = OP_CLR;
         ex_len = 2'd1;
      end else if (std_hit) begin
         op     = OP_STD;
         ex_len = 2'd2;
      end else if (icall_hit) begin
         op     = OP_ICALL;
         ex_len = 2'd2;
      end else if (lpm_hit) begin
         op     = OP_LPM;
         ex_len = 2'd3;
      end
   end

   assign reg_fld = ir_word[4 +: IDX_W];
   assign disp    = {ir_word[13], ir_word[11:10], ir_word[2:0]};

endmodule

// File: rtl/mcs_step.sv
`timescale 1ns/1ps
module mcs_step
   import mcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  op_e        op,
   input  logic [1:0] ex_len,
   output step_e      step
);

   step_e nxt;

   always_comb begin
      if (step == ST_FETCH) begin
         nxt = ST_EX1;
      end else if (2'(step) == ex_len) begin
         nxt = ST_FETCH;
      end else begin
         nxt = step_e'(2'(step) + 2'd1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) step <= ST_FETCH;
      else     step <= nxt;
   end

   // R1: reset leaves the sequencer in fetch
   p_reset_to_fetch_r1: assert property (@(posedge clk)
      rst |=> step == ST_FETCH);

   // R3: fetch is always followed by the first execute step
   p_fetch_then_ex1_r3: assert property (@(posedge clk) disable iff (rst)
      step == ST_FETCH |=> step == ST_EX1);

   // R4: clear has a single execute step
   p_clr_single_r4: assert property (@(posedge clk) disable iff (rst)
      (step == ST_EX1 && op == OP_CLR) |=> step == ST_FETCH);

   // R9: only the program load reaches a third execute step
   p_ex3_is_lpm_r9: assert property (@(posedge clk) disable iff (rst)
      step == ST_EX3 |-> op == OP_LPM);

endmodule

// File: rtl/mcs_ctl.sv
`timescale 1ns/1ps
module mcs_ctl
   import mcs_pkg::*;
#(
   parameter int IDX_W    = 5,
   parameter int DISP_W   = 6,
   parameter int FLAG_W   = 8,
   parameter int PTR_Y_LO = 28,
   parameter int PTR_Z_LO = 30
) (
   input  logic              rst,
   input  step_e             step,
   input  op_e               op,
   input  logic [IDX_W-1:0]  reg_fld,
   input  logic [DISP_W-1:0] disp,
   input  logic              z_lsb,
   output logic              ir_ld,
   output logic              pc_ld,
   output logic              npc_ld,
   output logic              ret_ld,
   output logic              pc_hi_ld,
   output logic              pc_lo_ld,
   output logic              sp_ld,
   output logic              sp_dec,
   output logic              rf_we_a,
   output logic              rf_we_b,
   output logic [IDX_W-1:0]  wa_idx,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [IDX_W-1:0]  ra_idx,
   output logic [IDX_W-1:0]  rb_idx,
   output logic [3:0]        alu_op,
   output logic [FLAG_W-1:0] flag_we,
   output logic              rf_src,
   output logic              agu_ld,
   output logic [DISP_W-1:0] agu_disp,
   output logic              dm_we,
   output logic              dm_addr_sel,
   output logic              dm_wdata_sel,
   output logic              pm_addr_sel,
   output logic              pm_byte_hi,
   output logic              mdr_ld
);

   localparam logic [IDX_W-1:0]  Y_LO = IDX_W'(PTR_Y_LO);
   localparam logic [IDX_W-1:0]  Y_HI = IDX_W'(PTR_Y_LO + 1);
   localparam logic [IDX_W-1:0]  Z_LO = IDX_W'(PTR_Z_LO);
   localparam logic [IDX_W-1:0]  Z_HI = IDX_W'(PTR_Z_LO + 1);
   localparam logic [FLAG_W-1:0] CLR_FLAGS = FLAG_W'((1 << FLAG_POS_Z) | (1 << FLAG_POS_N) |
                                                     (1 << FLAG_POS_V) | (1 << FLAG_POS_S));

   always_comb begin
      ir_ld = 1'b0; pc_ld = 1'b0; npc_ld = 1'b0; ret_ld = 1'b0;
      pc_hi_ld = 1'b0; pc_lo_ld = 1'b0; sp_ld = 1'b0; sp_dec = 1'b0;
      rf_we_a = 1'b0; rf_we_b = 1'b0;
      wa_idx = '0; wb_idx = '0; ra_idx = '0; rb_idx = '0;
      alu_op = ALU_IDLE; flag_we = '0; rf_src = 1'b0;
      agu_ld = 1'b0; agu_disp = '0;
      dm_we = 1'b0; dm_addr_sel = 1'b0; dm_wdata_sel = 1'b0;
      pm_addr_sel = 1'b0; pm_byte_hi = 1'b0; mdr_ld = 1'b0;
      if (!rst) begin
         unique case (step)
            ST_FETCH: begin
               ir_ld  = 1'b1;
               pc_ld  = 1'b1;
               npc_ld = 1'b1;
               ret_ld = 1'b1;
            end
            ST_EX1: begin
               case (op)
                  OP_CLR: begin
                     rf_we_a = 1'b1;
                     wa_idx  = reg_fld;
                     ra_idx  = reg_fld;
                     rb_idx  = reg_fld;
                     alu_op  = ALU_XOR;
                     flag_we = CLR_FLAGS;
                  end
                  OP_STD: begin
                     ra_idx   = Y_LO;
                     rb_idx   = Y_HI;
                     agu_ld   = 1'b1;
                     agu_disp = disp;
                  end
                  OP_ICALL: begin
                     dm_we        = 1'b1;
                     dm_addr_sel  = 1'b1;
                     dm_wdata_sel = 1'b1;
                     sp_ld        = 1'b1;
                     sp_dec       = 1'b1;
                  end
                  OP_LPM: begin
                     ra_idx = Z_LO;
                     rb_idx = Z_HI;
                     agu_ld = 1'b1;
                  end
                  default: ;
               endcase
            end
            ST_EX2: begin
               case (op)
                  OP_STD: begin
                     dm_we  = 1'b1;
                     ra_idx = reg_fld;
                  end
                  OP_ICALL: begin
                     ra_idx   = Z_LO;
                     rb_idx   = Z_HI;
                     pc_hi_ld = 1'b1;
                     pc_lo_ld = 1'b1;
                  end
                  OP_LPM: begin
                     pm_addr_sel = 1'b1;
                     mdr_ld      = 1'b1;
                     pm_byte_hi  = z_lsb;
                  end
                  default: ;
               endcase
            end
            ST_EX3: begin
               if (op == OP_LPM) begin
                  rf_we_a = 1'b1;
                  wa_idx  = reg_fld;
                  rf_src  = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/mc_sequencer.sv
`timescale 1ns/1ps
module mc_sequencer
   import mcs_pkg::*;
#(
   parameter int IR_W     = 16,
   parameter int IDX_W    = 5,
   parameter int DISP_W   = 6,
   parameter int FLAG_W   = 8,
   parameter int PTR_Y_LO = 28,
   parameter int PTR_Z_LO = 30,
   parameter bit LPM_EN   = 1'b1,
   parameter bit ICALL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IR_W-1:0]   ir_word,
   input  logic              z_lsb,
   output logic              ir_ld,
   output logic              pc_ld,
   output logic              npc_ld,
   output logic              ret_ld,
   output logic              pc_hi_ld,
   output logic              pc_lo_ld,
   output logic              sp_ld,
   output logic              sp_dec,
   output logic              rf_we_a,
   output logic              rf_we_b,
   output logic [IDX_W-1:0]  wa_idx,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [IDX_W-1:0]  ra_idx,
   output logic [IDX_W-1:0]  rb_idx,
   output logic [3:0]        alu_op,
   output logic [FLAG_W-1:0] flag_we,
   output logic              rf_src,
   output logic              agu_ld,
   output logic [DISP_W-1:0] agu_disp,
   output logic              dm_we,
   output logic              dm_addr_sel,
   output logic              dm_wdata_sel,
   output logic              pm_addr_sel,
   output logic              pm_byte_hi,
   output logic              mdr_ld
);

   localparam int NUM_REGS = 1 << IDX_W;

   if (PTR_Y_LO % 2 != 0 || PTR_Z_LO % 2 != 0) begin : g_bad_align
      $error("mc_sequencer: pointer pairs must start on an even register");
   end
   if (PTR_Y_LO + 1 >= NUM_REGS || PTR_Z_LO + 1 >= NUM_REGS) begin : g_bad_range
      $error("mc_sequencer: pointer pair exceeds the register file");
   end
   if (FLAG_W <= FLAG_POS_S) begin : g_bad_flags
      $error("mc_sequencer: flag mask too narrow");
   end

   op_e              op;
   step_e            step;
   logic [IDX_W-1:0] reg_fld;
   logic [DISP_W-1:0] disp;
   logic [1:0]       ex_len;

   mcs_decode #(
      .IR_W(IR_W), .IDX_W(IDX_W), .DISP_W(DISP_W),
      .LPM_EN(LPM_EN), .ICALL_EN(ICALL_EN)
   ) u_decode (
      .ir_word(ir_word), .op(op), .reg_fld(reg_fld), .disp(disp), .ex_len(ex_len)
   );

   mcs_step u_step (
      .clk(clk), .rst(rst), .op(op), .ex_len(ex_len), .step(step)
   );

   mcs_ctl #(
      .IDX_W(IDX_W), .DISP_W(DISP_W), .FLAG_W(FLAG_W),
      .PTR_Y_LO(PTR_Y_LO), .PTR_Z_LO(PTR_Z_LO)
   ) u_ctl (
      .rst(rst), .step(step), .op(op), .reg_fld(reg_fld), .disp(disp), .z_lsb(z_lsb),
      .ir_ld(ir_ld), .pc_ld(pc_ld), .npc_ld(npc_ld), .ret_ld(ret_ld),
      .pc_hi_ld(pc_hi_ld), .pc_lo_ld(pc_lo_ld), .sp_ld(sp_ld), .sp_dec(sp_dec),
      .rf_we_a(rf_we_a), .rf_we_b(rf_we_b),
      .wa_idx(wa_idx), .wb_idx(wb_idx), .ra_idx(ra_idx), .rb_idx(rb_idx),
      .alu_op(alu_op), .flag_we(flag_we), .rf_src(rf_src),
      .agu_ld(agu_ld), .agu_disp(agu_disp),
      .dm_we(dm_we), .dm_addr_sel(dm_addr_sel), .dm_wdata_sel(dm_wdata_sel),
      .pm_addr_sel(pm_addr_sel), .pm_byte_hi(pm_byte_hi), .mdr_ld(mdr_ld)
   );

   // R1: reset silences every write and load
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |-> !(ir_ld || pc_ld || npc_ld || ret_ld || rf_we_a || dm_we ||
                sp_ld || pc_hi_ld || pc_lo_ld || mdr_ld || agu_ld));

   // R2: the fetch step loads IR, PC, next-PC and return address together
   p_fetch_loads_r2: assert property (@(posedge clk) disable iff (rst)
      step == ST_FETCH |-> (ir_ld && pc_ld && npc_ld && ret_ld && !dm_we && !rf_we_a));

   // R3: next-PC is never loaded during execute
   p_no_npc_in_ex_r3: assert property (@(posedge clk) disable iff (rst)
      step != ST_FETCH |-> !npc_ld && !ir_ld);

   // R8: the call's PC load follows its stack push
   p_call_pc_after_push_r8: assert property (@(posedge clk) disable iff (rst)
      (pc_hi_ld && step == ST_EX2) |-> ($past(dm_we) && $past(sp_dec)));

   // R9: program-memory byte lands in the register file in the last step
   p_lpm_writeback_r9: assert property (@(posedge clk) disable iff (rst)
      step == ST_EX3 |-> (rf_we_a && rf_src && $past(mdr_ld)));

   // R10: at most one kind of state update per cycle
   p_single_target_r10: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rf_we_a, dm_we, pc_hi_ld, mdr_ld}));

endmodule

// File: tb/test_mc_sequencer.sv
`timescale 1ns/1ps
module test_mc_sequencer;

   localparam int KN = 0, KC = 1, KS = 2, KI = 3, KL = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [15:0] ir_word = 16'h0000;
   logic z_lsb = 1'b0;

   logic ir_ld, pc_ld, npc_ld, ret_ld, pc_hi_ld, pc_lo_ld, sp_ld, sp_dec;
   logic rf_we_a, rf_we_b, rf_src, agu_ld, dm_we, dm_addr_sel, dm_wdata_sel;
   logic pm_addr_sel, pm_byte_hi, mdr_ld;
   logic [4:0] wa_idx, wb_idx, ra_idx, rb_idx;
   logic [3:0] alu_op;
   logic [7:0] flag_we;
   logic [5:0] agu_disp;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mc_sequencer i_mc_sequencer (
      .clk(clk), .rst(rst), .ir_word(ir_word), .z_lsb(z_lsb),
      .ir_ld(ir_ld), .pc_ld(pc_ld), .npc_ld(npc_ld), .ret_ld(ret_ld),
      .pc_hi_ld(pc_hi_ld), .pc_lo_ld(pc_lo_ld), .sp_ld(sp_ld), .sp_dec(sp_dec),
      .rf_we_a(rf_we_a), .rf_we_b(rf_we_b),
      .wa_idx(wa_idx), .wb_idx(wb_idx), .ra_idx(ra_idx), .rb_idx(rb_idx),
      .alu_op(alu_op), .flag_we(flag_we), .rf_src(rf_src),
      .agu_ld(agu_ld), .agu_disp(agu_disp),
      .dm_we(dm_we), .dm_addr_sel(dm_addr_sel), .dm_wdata_sel(dm_wdata_sel),
      .pm_addr_sel(pm_addr_sel), .pm_byte_hi(pm_byte_hi), .mdr_ld(mdr_ld)
   );

   wire [55:0] act = {ir_ld, pc_ld, npc_ld, ret_ld, pc_hi_ld, pc_lo_ld, sp_ld, sp_dec,
                      rf_we_a, rf_we_b, wa_idx, wb_idx, ra_idx, rb_idx, alu_op, flag_we,
                      rf_src, agu_ld, agu_disp, dm_we, dm_addr_sel, dm_wdata_sel,
                      pm_addr_sel, pm_byte_hi, mdr_ld};

   function automatic logic [15:0] enc_clr(int d);
      return 16'(32'h2400 | (((d >> 4) & 1) << 9) | ((d & 31) << 4) | (d & 15));
   endfunction

   function automatic logic [15:0] enc_std(int q, int r);
      return 16'(32'h8208 | (((q >> 5) & 1) << 13) | (((q >> 3) & 3) << 10) |
                 ((r & 31) << 4) | (q & 7));
   endfunction

   function automatic logic [15:0] enc_lpm(int d);
      return 16'(32'h9004 | ((d & 31) << 4));
   endfunction

   function automatic int ex_steps(int k);
      case (k)
         KS, KI:  return 2;
         KL:      return 3;
         default: return 1;
      endcase
   endfunction

   function automatic string tag_of(int k, int ph);
      if (ph == 0) return "R2";
      case (k)
         KC:      return "R4";
         KS:      return (ph == 1) ? "R5" : "R6";
         KI:      return (ph == 1) ? "R7" : "R8";
         KL:      return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [55:0] exp_vec(int ph, int k, int rg, int q, bit z, bit r);
      logic il, pl, nl, rl, phl, pll, spl, spd, wea, web, rfs, agl, dmw, dmas, dmws, pms, pbh, mdl;
      logic [4:0] wa, wb, ra, rb;
      logic [3:0] alu;
      logic [7:0] fl;
      logic [5:0] dp;
      {il, pl, nl, rl, phl, pll, spl, spd, wea, web} = '0;
      {rfs, agl, dmw, dmas, dmws, pms, pbh, mdl} = '0;
      {wa, wb, ra, rb} = '0;
      alu = '0; fl = '0; dp = '0;
      if (!r) begin
         if (ph == 0) begin
            {il, pl, nl, rl} = 4'b1111;
         end else if (ph == 1) begin
            if (k == KC) begin
               wea = 1; wa = 5'(rg); ra = 5'(rg); rb = 5'(rg); alu = 4'd6; fl = 8'h1E;
            end else if (k == KS) begin
               ra = 5'd28; rb = 5'd29; agl = 1; dp = 6'(q);
            end else if (k == KI) begin
               dmw = 1; dmas = 1; dmws = 1; spl = 1; spd = 1;
            end else if (k == KL) begin
               ra = 5'd30; rb = 5'd31; agl = 1;
            end
         end else if (ph == 2) begin
            if (k == KS) begin
               dmw = 1; ra = 5'(rg);
            end else if (k == KI) begin
               ra = 5'd30; rb = 5'd31; phl = 1; pll = 1;
            end else if (k == KL) begin
               pms = 1; mdl = 1; pbh = z;
            end
         end else if (ph == 3 && k == KL) begin
            wea = 1; wa = 5'(rg); rfs = 1;
         end
      end
      return {il, pl, nl, rl, phl, pll, spl, spd, wea, web, wa, wb, ra, rb, alu, fl,
              rfs, agl, dp, dmw, dmas, dmws, pms, pbh, mdl};
   endfunction

   task automatic check_vec(int ph, int k, int rg, int q, string tag);
      logic [55:0] e;
      e = exp_vec(ph, k, rg, q, z_lsb, rst);
      checks++;
      if (act !== e) begin
         errors++;
         $display("FAIL %s step %0d word %h: actual %h expected %h", tag, ph, ir_word, act, e);
      end
   endtask

   // Called exactly at a falling edge while the sequencer is in fetch.
   task automatic run(logic [15:0] w, int k, int rg, int q, bit z);
      ir_word = w;
      z_lsb = z;
      #1 check_vec(0, k, rg, q, "R2");
      @(negedge clk);
      for (int p = 1; p <= ex_steps(k); p++) begin
         #1 check_vec(p, k, rg, q, tag_of(k, p));
         checks++;
         if (npc_ld !== 1'b0) begin
            errors++;
            $display("FAIL R3 next-PC load in execute step %0d: actual %b expected 0", p, npc_ld);
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 check_vec(0, KN, 0, 0, "R1");
      @(negedge clk);
      rst = 1'b0;

      run(enc_clr(0), KC, 0, 0, 0);
      run(enc_clr(31), KC, 31, 0, 0);
      run(enc_clr(17), KC, 17, 0, 1);
      run(16'h2434, KN, 0, 0, 0);           // R10: exclusive-or of r3 and r4
      run(enc_std(0, 5), KS, 5, 0, 0);
      run(enc_std(63, 31), KS, 31, 63, 0);
      run(enc_std(21, 10), KS, 10, 21, 1);
      run(16'h9509, KI, 0, 0, 0);
      run(enc_lpm(7), KL, 7, 0, 0);
      run(enc_lpm(7), KL, 7, 0, 1);
      run(enc_lpm(0), KL, 0, 0, 1);
      run(16'h9508, KN, 0, 0, 0);
      run(16'h0000, KN, 0, 0, 0);
      run(16'h8008, KN, 0, 0, 0);
      run(16'h9005, KN, 0, 0, 1);

      // R1: reset during the second step of a program load
      ir_word = enc_lpm(12);
      z_lsb = 1'b1;
      #1 check_vec(0, KL, 12, 0, "R2");
      @(negedge clk);
      #1 check_vec(1, KL, 12, 0, "R9");
      @(negedge clk);
      rst = 1'b1;
      #1 check_vec(2, KL, 12, 0, "R1");
      @(negedge clk);
      #1 check_vec(3, KL, 12, 0, "R1");
      @(negedge clk);
      rst = 1'b0;

      run(enc_clr(9), KC, 9, 0, 0);        // R1: first cycle after reset is fetch
      run(16'h9509, KI, 0, 0, 1);
      run(enc_std(1, 2), KS, 2, 1, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual still running expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule